// File: doc/BRIEF.md
# Logic Instruction Execute Unit

This block carries out the bitwise-logic group of a 32-bit CPU whose instructions are 16 bits wide. A caller presents one instruction word with a valid strobe. The block decodes the word and runs it against a sixteen-entry register file and a global base register, both held inside the block. It updates a single test flag and, for the memory forms, does a byte read-modify-write over a simple synchronous byte port. A one-cycle done pulse marks the last cycle of every legal instruction.

The group has four kinds of forms. Register forms work on two general registers. Immediate forms work on R0 with an 8-bit constant. Indexed byte forms work on the byte at R0 plus the base register. An atomic test-and-set works on the byte addressed by a general register. A load port lets the rest of the CPU preset the registers and the base register between instructions. A read-only select port lets it look at any register.

The memory port is synchronous. A read strobe in one cycle returns its data in the next cycle. A write strobe stores the byte at the clock edge that ends the cycle in which it is high.

Top module: `logic_exec_unit`

## Requirements
- R1: The register forms AND, XOR and OR store Rn op Rm into Rn. They are encoded 0010nnnnmmmm10xx, where the low two bits xx select TST=00, AND=01, XOR=10 and OR=11.
- R2: The word 0110nnnnmmmm0111 stores the bitwise complement of Rm into Rn.
- R3: Every test form stores no register and writes no memory byte. It sets the flag to 1 when the AND of its two operands is zero, and clears the flag otherwise.
- R4: The words 110010xx iiiiiiii combine R0 with the immediate, zero-extended to 32 bits, and store the result in R0. The bits xx select the operation with the same code as R1.
- R5: The words 110011xx iiiiiiii read the byte at address R0+base and combine it with the immediate, using the same operation code as R1. Every form except test writes the result back to the same address. A read and a write are never strobed in the same cycle.
- R6: The word 0100nnnn00011011 reads the byte addressed by Rn and sets the flag to 1 if that byte is zero, clearing it otherwise. It then writes the byte back with bit 7 forced to 1.
- R7: The done pulse comes 1 cycle after acceptance for the register and immediate forms, and 3 cycles after acceptance for the indexed byte forms.
- R8: AND, OR, XOR and complement leave the flag unchanged.
- R9: The test-and-set form ends 4 cycles after acceptance. The lock output is high from its read cycle through its write cycle.
- R10: Any other word raises the illegal output for one cycle, 1 cycle after acceptance. It gives no done pulse and changes no register, no flag and no memory byte.
- R11: After reset, done, illegal, both memory strobes, lock and the flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word present; taken when the unit is idle |
| instr | input | 16 | Instruction word |
| done | output | 1 | Last cycle of a legal instruction |
| illegal | output | 1 | Word outside the group was rejected |
| t_flag | output | 1 | Test flag |
| ld_en | input | 1 | Write ld_data into register ld_sel |
| ld_gbr | input | 1 | Write ld_data into the base register |
| ld_sel | input | 4 | Register index for ld_en |
| ld_data | input | 32 | Preset value |
| obs_sel | input | 4 | Register index to observe |
| obs_data | output | 32 | Contents of register obs_sel |
| mem_addr | output | 32 | Byte address |
| mem_rd | output | 1 | Byte read strobe; data expected next cycle |
| mem_wr | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read data |
| mem_lock | output | 1 | Bus held for an atomic test-and-set |

## Verification
The assertions rely on three things about the surroundings. First, a new word is offered only while the unit is idle, which is the cycle of done or illegal or later. Second, load strobes never coincide with an executing instruction. Third, the byte memory returns read data exactly one cycle after the read strobe. The stimulus meets all three. It holds each word valid for one cycle and then waits for done or illegal before driving the next. It performs all presets between instructions. Its memory model answers every read on the following clock edge.

// File: rtl/lxu_pkg.sv
package lxu_pkg;
  localparam int INSTR_W = 16;
  localparam int FIELD_W = 4;

  typedef enum logic [1:0] {
    LOP_TST = 2'd0,
    LOP_AND = 2'd1,
    LOP_XOR = 2'd2,
    LOP_OR  = 2'd3
  } lop_e;

  typedef enum logic [2:0] {
    FK_BAD, FK_REG, FK_INV, FK_IMM, FK_GBR, FK_TAS
  } fkind_e;

  typedef struct packed {
    fkind_e              kind;
    lop_e                op;
    logic [FIELD_W-1:0]  rn;
    logic [FIELD_W-1:0]  rm;
    logic [7:0]          imm;
  } dec_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_RD, ST_MOD, ST_TASW
  } st_e;
endpackage

// File: rtl/lxu_decode.sv
module lxu_decode
  import lxu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec      = '0;
    dec.kind = FK_BAD;
    dec.op   = lop_e'(instr[1:0]);
    dec.rn   = instr[11:8];
    dec.rm   = instr[7:4];
    dec.imm  = instr[7:0];
    if (instr[15:12] == 4'h2 && instr[3:2] == 2'b10) begin
      dec.kind = FK_REG;
    end else if (instr[15:12] == 4'h6 && instr[3:0] == 4'h7) begin
      dec.kind = FK_INV;
    end else if (instr[15:10] == 6'b110010) begin
      dec.kind = FK_IMM;
      dec.op   = lop_e'(instr[9:8]);
    end else if (instr[15:10] == 6'b110011) begin
      dec.kind = FK_GBR;
      dec.op   = lop_e'(instr[9:8]);
    end else if (instr[15:12] == 4'h4 && instr[7:0] == 8'h1B) begin
      dec.kind = FK_TAS;
    end
  end
endmodule

// File: rtl/lxu_alu.sv
module lxu_alu
  import lxu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  lop_e         op,
  input  logic         inv,
  output logic [W-1:0] res,
  output logic         zero
);
  always_comb begin
    case (op)
      LOP_OR:  res = a | b;
      LOP_XOR: res = a ^ b;
      default: res = a & b;
    endcase
    if (inv) res = ~b;
    zero = ((a & b) == '0);
  end
endmodule

// File: rtl/lxu_regfile.sv
module lxu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [XLEN-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][XLEN-1:0] rdata
);
  logic [XLEN-1:0] store [NREG];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = store[raddr[p]];
  end
endmodule

// File: rtl/logic_exec_unit.sv
module logic_exec_unit
  import lxu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NREG    = 16,
  parameter int BYTE_W  = 8,
  parameter int TAS_BIT = 7,
  localparam int AW     = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_valid,
  input  logic [INSTR_W-1:0]  instr,
  output logic                done,
  output logic                illegal,
  output logic                t_flag,
  input  logic                ld_en,
  input  logic                ld_gbr,
  input  logic [AW-1:0]       ld_sel,
  input  logic [XLEN-1:0]     ld_data,
  input  logic [AW-1:0]       obs_sel,
  output logic [XLEN-1:0]     obs_data,
  output logic [XLEN-1:0]     mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [BYTE_W-1:0]   mem_wdata,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic                mem_lock
);
  localparam logic [BYTE_W-1:0] TAS_MASK = BYTE_W'(1) << TAS_BIT;

  dec_t              d;
  st_e               st;
  lop_e              op_q;
  logic [7:0]        imm_q;
  logic              tas_q;
  logic [XLEN-1:0]   gbr;
  logic [3:0][XLEN-1:0] rd_v;
  logic [XLEN-1:0]   rn_v, rm_v, r0_v;
  logic [XLEN-1:0]   w_a, w_b, w_res;
  logic              w_zero;
  logic [BYTE_W-1:0] b_res;
  logic              b_zero;
  logic              accept, single, ex_we;
  logic [AW-1:0]     ex_waddr;

  lxu_decode u_dec (.instr(instr), .dec(d));

  assign accept = (st == ST_IDLE) && instr_valid;
  assign single = accept && (d.kind == FK_REG || d.kind == FK_INV || d.kind == FK_IMM);
  assign ex_we  = accept && (d.kind == FK_INV ||
                  ((d.kind == FK_REG || d.kind == FK_IMM) && d.op != LOP_TST));
  assign ex_waddr = (d.kind == FK_IMM) ? '0 : AW'(d.rn);

  lxu_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(4)) u_rf (
    .clk   (clk),
    .we    (ex_we | ld_en),
    .waddr (ex_we ? ex_waddr : ld_sel),
    .wdata (ex_we ? w_res : ld_data),
    .raddr ({obs_sel, AW'(0), AW'(d.rm), AW'(d.rn)}),
    .rdata (rd_v)
  );

  assign rn_v     = rd_v[0];
  assign rm_v     = rd_v[1];
  assign r0_v     = rd_v[2];
  assign obs_data = rd_v[3];

  assign w_a = (d.kind == FK_IMM) ? r0_v : rn_v;
  assign w_b = (d.kind == FK_IMM) ? {{(XLEN-8){1'b0}}, d.imm} : rm_v;

  lxu_alu #(.W(XLEN)) u_walu (
    .a(w_a), .b(w_b), .op(d.op), .inv(d.kind == FK_INV),
    .res(w_res), .zero(w_zero)
  );

  lxu_alu #(.W(BYTE_W)) u_balu (
    .a(mem_rdata), .b(BYTE_W'(imm_q)), .op(op_q), .inv(1'b0),
    .res(b_res), .zero(b_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      illegal   <= 1'b0;
      t_flag    <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_lock  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      op_q      <= LOP_TST;
      imm_q     <= '0;
      tas_q     <= 1'b0;
      gbr       <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      if (ld_gbr) gbr <= ld_data;
      case (st)
        ST_IDLE: begin
          mem_lock <= 1'b0;
          if (instr_valid) begin
            case (d.kind)
              FK_REG, FK_INV, FK_IMM: begin
                done <= 1'b1;
                if (d.kind != FK_INV && d.op == LOP_TST) t_flag <= w_zero;
              end
              FK_GBR: begin
                mem_addr <= r0_v + gbr;
                mem_rd   <= 1'b1;
                op_q     <= d.op;
                imm_q    <= d.imm;
                tas_q    <= 1'b0;
                st       <= ST_RD;
              end
              FK_TAS: begin
                mem_addr <= rn_v;
                mem_rd   <= 1'b1;
                mem_lock <= 1'b1;
                tas_q    <= 1'b1;
                st       <= ST_RD;
              end
              default: illegal <= 1'b1;
            endcase
          end
        end
        ST_RD: st <= ST_MOD;
        ST_MOD: begin
          if (tas_q) begin
            t_flag    <= (mem_rdata == '0);
            mem_wdata <= mem_rdata | TAS_MASK;
            st        <= ST_TASW;
          end else begin
            if (op_q == LOP_TST) begin
              t_flag <= b_zero;
            end else begin
              mem_wr    <= 1'b1;
              mem_wdata <= b_res;
            end
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: begin
          mem_wr <= 1'b1;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
      endcase
    end
  end

  // R7: register and immediate forms finish one cycle after acceptance
  p_single_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    single |=> (done && !mem_rd));

  // R7: indexed byte forms finish two cycles after their read strobe
  p_byte_latency_r7: assert property (@(posedge clk) disable iff (rst)
    $past(mem_rd && !mem_lock, 2) |-> done);

  // R8: non-test logic forms keep the flag
  p_keep_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && (d.kind == FK_INV ||
      ((d.kind == FK_REG || d.kind == FK_IMM) && d.op != LOP_TST)))
    |=> $stable(t_flag));

  // R9: lock held through the wait cycle
  p_lock_mid_r9: assert property (@(posedge clk) disable iff (rst)
    $past(mem_rd && mem_lock) |-> mem_lock);

  // R9: locked read leads to locked write and done three cycles later
  p_lock_write_r9: assert property (@(posedge clk) disable iff (rst)
    $past(mem_rd && mem_lock, 3) |-> (done && mem_wr && mem_lock));

  // R10: a rejected word produces no done, no access and no flag change
  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!done && !mem_rd && !mem_wr && $stable(t_flag)));

  // R5: read and write strobes never overlap
  p_rw_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

// File: tb/tb_logic_exec_unit.sv
`timescale 1ns/1ps
module tb_logic_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        done, illegal, t_flag;
  logic        ld_en = 1'b0, ld_gbr = 1'b0;
  logic [3:0]  ld_sel = '0;
  logic [31:0] ld_data = '0;
  logic [3:0]  obs_sel = '0;
  logic [31:0] obs_data, mem_addr;
  logic        mem_rd, mem_wr, mem_lock;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #2 clk = ~clk;

  logic_exec_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .done(done), .illegal(illegal), .t_flag(t_flag),
    .ld_en(ld_en), .ld_gbr(ld_gbr), .ld_sel(ld_sel), .ld_data(ld_data),
    .obs_sel(obs_sel), .obs_data(obs_data),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_lock(mem_lock)
  );

  logic [7:0] mem  [256];
  logic [7:0] emem [256];
  logic [31:0] er [16];
  logic [31:0] egbr;
  bit          et;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  typedef struct {
    int         lat;
    bit         ill;
    bit         t;
    int         rd;
    logic [31:0] rv;
    bit         mw;
    logic [7:0] ma;
    logic [7:0] md;
    bit         tas;
    string      req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lop(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      2'd3:    return a | b;
      2'd2:    return a ^ b;
      default: return a & b;
    endcase
  endfunction

  function automatic logic [15:0] f_reg(logic [1:0] op, logic [3:0] n, logic [3:0] m);
    return {4'h2, n, m, 2'b10, op};
  endfunction
  function automatic logic [15:0] f_not(logic [3:0] n, logic [3:0] m);
    return {4'h6, n, m, 4'h7};
  endfunction
  function automatic logic [15:0] f_imm(logic [1:0] op, logic [7:0] i);
    return {6'b110010, op, i};
  endfunction
  function automatic logic [15:0] f_gbr(logic [1:0] op, logic [7:0] i);
    return {6'b110011, op, i};
  endfunction
  function automatic logic [15:0] f_tas(logic [3:0] n);
    return {4'h4, n, 8'h1B};
  endfunction

  task automatic load(int i, logic [31:0] v);
    ld_en = 1'b1; ld_sel = 4'(i); ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    er[i] = v;
  endtask

  task automatic load_gbr(logic [31:0] v);
    ld_gbr = 1'b1; ld_data = v;
    @(negedge clk);
    ld_gbr = 1'b0;
    egbr = v;
  endtask

  // driver: compute expectation, push, drive one cycle, wait for completion
  task automatic issue(logic [15:0] w, string req);
    exp_t e;
    logic [3:0] n, m;
    logic [7:0] a8, b8;
    n = w[11:8]; m = w[7:4];
    e.lat = 1; e.ill = 0; e.rd = 0; e.mw = 0; e.ma = '0; e.md = '0; e.tas = 0; e.req = req;
    if (w[15:12] == 4'h2 && w[3:2] == 2'b10) begin
      e.rd = n;
      if (w[1:0] == 2'd0) et = ((er[n] & er[m]) == 0);
      else er[n] = lop(w[1:0], er[n], er[m]);
    end else if (w[15:12] == 4'h6 && w[3:0] == 4'h7) begin
      e.rd = n; er[n] = ~er[m];
    end else if (w[15:10] == 6'b110010) begin
      if (w[9:8] == 2'd0) et = ((er[0] & {24'h0, w[7:0]}) == 0);
      else er[0] = lop(w[9:8], er[0], {24'h0, w[7:0]});
    end else if (w[15:10] == 6'b110011) begin
      e.lat = 3; e.ma = 8'(er[0] + egbr); a8 = emem[e.ma];
      if (w[9:8] == 2'd0) et = ((a8 & w[7:0]) == 0);
      else begin
        b8 = 8'(lop(w[9:8], {24'h0, a8}, {24'h0, w[7:0]}));
        e.mw = 1; e.md = b8; emem[e.ma] = b8;
      end
    end else if (w[15:12] == 4'h4 && w[7:0] == 8'h1B) begin
      e.lat = 4; e.tas = 1; e.rd = n; e.ma = er[n][7:0]; a8 = emem[e.ma];
      et = (a8 == 0); e.mw = 1; e.md = a8 | 8'h80; emem[e.ma] = e.md;
    end else begin
      e.ill = 1;
    end
    e.t = et; e.rv = er[e.rd];
    q.push_back(e);
    instr = w; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    while (!(done || illegal)) @(negedge clk);
  endtask

  // monitor: measure latency and compare results at completion
  initial begin
    int cnt = 0;
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (!rst && q.size() > 0) begin
        cnt++;
        if (q[0].tas && (mem_rd || mem_wr))
          chk("R9", "lock during access", 32'(mem_lock), 32'd1);
        if (mem_rd && mem_wr) chk("R5", "rd/wr overlap", 32'd1, 32'd0);
        if (done || illegal) begin
          e = q.pop_front();
          chk(e.tas ? "R9" : "R7", {e.req, " latency"}, 32'(cnt), 32'(e.lat));
          chk("R10", {e.req, " illegal"}, 32'(illegal), 32'(e.ill));
          chk("R10", {e.req, " done"}, 32'(done), 32'(!e.ill));
          chk(e.req, "flag", 32'(t_flag), 32'(e.t));
          chk(e.req, "mem write strobe", 32'(mem_wr), 32'(e.mw));
          if (e.mw) begin
            chk(e.req, "mem addr", mem_addr, 32'(e.ma));
            chk(e.req, "mem data", 32'(mem_wdata), 32'(e.md));
          end
          if (e.tas) chk("R9", "lock at write", 32'(mem_lock), 32'd1);
          obs_sel = 4'(e.rd);
          #0.5;
          chk(e.req, $sformatf("reg R%0d", e.rd), obs_data, e.rv);
          cnt = 0;
        end else if (cnt > 8) begin
          chk("R7", "completion missing", 32'(cnt), 32'(q[0].lat));
          void'(q.pop_front());
          cnt = 0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      emem[i] = mem[i];
    end
    mem[8'h40] = 8'h00; emem[8'h40] = 8'h00;
    mem[8'h30] = 8'h5A; emem[8'h30] = 8'h5A;
    for (int i = 0; i < 16; i++) er[i] = '0;
    egbr = '0; et = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11", "done", 32'(done), 32'd0);
    chk("R11", "illegal", 32'(illegal), 32'd0);
    chk("R11", "mem_rd", 32'(mem_rd), 32'd0);
    chk("R11", "mem_wr", 32'(mem_wr), 32'd0);
    chk("R11", "lock", 32'(mem_lock), 32'd0);
    chk("R11", "flag", 32'(t_flag), 32'd0);

    for (int i = 0; i < 16; i++) load(i, 32'(i * 32'h0101_0101));
    load(0, 32'h0000_0010);
    load(1, 32'hF0F0_1234);
    load(2, 32'h0FF0_FF00);
    load(3, 32'h0F0F_0000);
    load(5, 32'h0000_0040);
    load(6, 32'h0000_0041);
    load(7, 32'hFFFF_FF00);
    load_gbr(32'h0000_0020);

    issue(f_reg(2'd0, 4'd3, 4'd1), "R3 tst zero");
    issue(f_reg(2'd1, 4'd1, 4'd2), "R1 R8 and");
    issue(f_reg(2'd3, 4'd2, 4'd3), "R1 R8 or");
    issue(f_reg(2'd2, 4'd3, 4'd7), "R1 R8 xor");
    issue(f_not(4'd4, 4'd7), "R2 R8 not");
    issue(f_reg(2'd0, 4'd1, 4'd2), "R3 tst nonzero");
    issue(f_not(4'd9, 4'd9), "R2 R8 not self");
    issue(f_reg(2'd0, 4'd7, 4'd4), "R3 tst zero again");

    load(0, 32'hABCD_12F0);
    issue(f_imm(2'd1, 8'h3C), "R4 and zext");
    issue(f_imm(2'd2, 8'hFF), "R4 R8 xor");
    issue(f_imm(2'd0, 8'h30), "R3 R4 tst zero");
    issue(f_imm(2'd0, 8'h01), "R3 R4 tst nonzero");
    issue(f_imm(2'd3, 8'h80), "R4 R8 or");

    load(0, 32'h0000_0010);
    issue(f_gbr(2'd1, 8'h0F), "R5 and.b");
    issue(f_gbr(2'd3, 8'hA0), "R5 or.b");
    issue(f_gbr(2'd2, 8'hFF), "R5 xor.b");
    issue(f_gbr(2'd0, 8'hAA), "R3 R5 tst.b zero");
    issue(f_gbr(2'd0, 8'h01), "R3 R5 tst.b nonzero");

    issue(16'hFFFF, "R10 all ones");
    issue(16'h2004, "R10 near reg form");
    issue(16'h401A, "R10 near tas");

    issue(f_tas(4'd5), "R6 tas zero byte");
    issue(f_tas(4'd5), "R6 tas set byte");
    issue(f_tas(4'd6), "R6 tas nonzero byte");
    issue(f_reg(2'd1, 4'd6, 4'd5), "R1 after tas");
    issue(16'h0000, "R10 zero word");

    @(negedge clk);
    chk("R5", "byte 0x30", 32'(mem[8'h30]), 32'(emem[8'h30]));
    chk("R6", "byte 0x40", 32'(mem[8'h40]), 32'(emem[8'h40]));
    chk("R6", "byte 0x41", 32'(mem[8'h41]), 32'(emem[8'h41]));
    chk("R10", "queue drained", 32'(q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule